// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

A twelve-pin general-purpose I/O port with a small memory-mapped register interface. The data register sits behind a 4096-word window. The word address of each access is itself a per-pin mask. A write changes only the pins whose mask bit is set. A read returns zero on every pin whose mask bit is clear. Software can therefore set, clear or sample one pin or any group of pins in a single bus access, with no read-modify-write and no separate set or clear registers.

A direction register selects, for each pin, whether the pin is an input or an output. The pads are modelled as three vectors:

- an input vector, which passes through a synchronizer before it is used;
- an output vector;
- an output-enable vector.

Read data is registered. It is returned in the cycle after the read strobe.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset the direction register and the output latch are all zeros. Every pin is an input, `pad_oe` is 0 and `pad_out` is 0.
- R2: A write with byte address bits [15:14] = 0 is a data write. Byte address bits [13:2] form the pin mask. Only pins whose mask bit is 1 take the value of the matching `bus_wdata` bit. Every other latch bit keeps its value.
- R3: A data read returns 0 on every pin whose mask bit is 0. Bits 31:12 of `bus_rdata` always read 0 after a data read.
- R4: Byte offset 0x3FFC (mask 0xFFF) reads or writes all twelve pins at once.
- R5: The direction register is at byte offset 0x8000. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. It reads back at the same offset, and write data bits above bit 11 are ignored.
- R6: `pad_oe` equals the direction register. `pad_out` carries the latch value only on pins whose direction bit is 1, and is 0 on input pins.
- R7: A data read returns the latch value for output pins and the synchronized pad level for input pins, each gated by the mask.
- R8: `pad_in` passes through a two-flop synchronizer. For a pad change applied before clock edge k, a read sampling at edges k and k+1 still shows the old level, and one sampling at edge k+2 shows the new level.
- R9: `bus_rdata` is loaded on the clock edge where `bus_re` is high and holds its value otherwise. A read of an unmapped address returns 0. A write to an unmapped address changes neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 12 | Pad input levels |
| pad_out | output | 12 | Pad output levels |
| pad_oe | output | 12 | Pad output enables (1 = driving) |

## Verification
The bench builds the port with its default parameters: twelve pins, a 16-bit byte address, 32-bit data and two synchronizer stages. With twelve pins, the full mask 0xFFF, single-bit masks, sparse multi-bit masks and the unmapped space above the window are all reachable by plain addresses. With two stages, the old-old-new progression of reads after a pad change is short enough to observe edge by edge. A mix of input and output pins lets one full-mask read show both the latch path and the pad path.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

  // Mask-gated merge: bits with sel=1 come from nw, others from old.
  function automatic logic [31:0] masked_merge(input logic [31:0] old,
                                               input logic [31:0] nw,
                                               input logic [31:0] sel);
    return (old & ~sel) | (nw & sel);
  endfunction

  // Per-pin visible level: outputs show the latch, inputs show the pad.
  function automatic logic [31:0] pin_level(input logic [31:0] latch,
                                            input logic [31:0] pad,
                                            input logic [31:0] dir);
    return (latch & dir) | (pad & ~dir);
  endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mgpio_decode.sv
module mgpio_decode #(
  parameter int          ADDR_W     = 16,
  parameter int          PIN_N      = 12,
  parameter logic [15:0] DIR_OFFSET = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic              data_wr,
  output logic              dir_wr,
  output logic              data_rd,
  output logic              dir_rd,
  output logic [PIN_N-1:0]  mask
);
  localparam int          WIN_TOP  = PIN_N + 2;
  localparam logic [ADDR_W-3:0] DIR_WORD = ADDR_W'(DIR_OFFSET) >> 2;

  logic in_data, in_dir;

  assign in_data = (addr[ADDR_W-1:WIN_TOP] == '0);
  assign in_dir  = (addr[ADDR_W-1:2] == DIR_WORD);
  assign mask    = addr[WIN_TOP-1:2];

  assign data_wr = we & in_data;
  assign dir_wr  = we & in_dir;
  assign data_rd = re & in_data;
  assign dir_rd  = re & in_dir;
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
  import mgpio_pkg::*;
#(
  parameter int PIN_N  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              dir_wr,
  input  logic [PIN_N-1:0]  mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [PIN_N-1:0]  latch_q,
  output logic [PIN_N-1:0]  dir_q
);
  logic [PIN_N-1:0] latch_next;
  logic             armed_q;

  assign latch_next = PIN_N'(masked_merge(32'(latch_q), 32'(wdata[PIN_N-1:0]), 32'(mask)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (data_wr) latch_q <= latch_next;
      if (dir_wr)  dir_q   <= wdata[PIN_N-1:0];
    end
  end

  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(data_wr) |-> ((latch_q & ~$past(mask)) == ($past(latch_q) & ~$past(mask)))); // R2
  AST_MASKED_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(data_wr) |-> ((latch_q & $past(mask)) == ($past(wdata[PIN_N-1:0]) & $past(mask)))); // R2
  AST_LATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !$past(data_wr) |-> $stable(latch_q)); // R9
  AST_DIR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !$past(dir_wr) |-> $stable(dir_q)); // R5
endmodule

// File: rtl/mgpio_readback.sv
module mgpio_readback
  import mgpio_pkg::*;
#(
  parameter int PIN_N  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic              data_rd,
  input  logic              dir_rd,
  input  logic [PIN_N-1:0]  mask,
  input  logic [PIN_N-1:0]  latch_q,
  input  logic [PIN_N-1:0]  dir_q,
  input  logic [PIN_N-1:0]  pad_sync,
  output logic [DATA_W-1:0] rdata
);
  logic [PIN_N-1:0] level;
  logic [PIN_N-1:0] data_view;
  logic             armed_q;

  assign level     = PIN_N'(pin_level(32'(latch_q), 32'(pad_sync), 32'(dir_q)));
  assign data_view = level & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (re) begin
        if (data_rd)     rdata <= DATA_W'(data_view);
        else if (dir_rd) rdata <= DATA_W'(dir_q);
        else             rdata <= '0;
      end
    end
  end

  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(data_rd) |-> ((rdata[PIN_N-1:0] & ~$past(mask)) == '0)); // R3
  AST_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(re) |-> (rdata[DATA_W-1:PIN_N] == '0)); // R3
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !$past(re) |-> $stable(rdata)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(re) && !$past(data_rd) && !$past(dir_rd) |-> (rdata == '0)); // R9
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port #(
  parameter int          PIN_N       = 12,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] DIR_OFFSET  = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_N-1:0]  pad_in,
  output logic [PIN_N-1:0]  pad_out,
  output logic [PIN_N-1:0]  pad_oe
);
  logic             data_wr, dir_wr, data_rd, dir_rd;
  logic [PIN_N-1:0] mask, latch_q, dir_q, pad_sync;

  mgpio_decode #(.ADDR_W(ADDR_W), .PIN_N(PIN_N), .DIR_OFFSET(DIR_OFFSET)) u_decode (
    .addr(bus_addr), .we(bus_we), .re(bus_re),
    .data_wr(data_wr), .dir_wr(dir_wr), .data_rd(data_rd), .dir_rd(dir_rd), .mask(mask)
  );

  mgpio_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  mgpio_regs #(.PIN_N(PIN_N), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .dir_wr(dir_wr), .mask(mask),
    .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
  );

  mgpio_readback #(.PIN_N(PIN_N), .DATA_W(DATA_W)) u_readback (
    .clk(clk), .rst_n(rst_n), .re(bus_re), .data_rd(data_rd), .dir_rd(dir_rd),
    .mask(mask), .latch_q(latch_q), .dir_q(dir_q), .pad_sync(pad_sync), .rdata(bus_rdata)
  );

  assign pad_oe  = dir_q;
  assign pad_out = latch_q & dir_q;

  AST_OUT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0)); // R6
  AST_RESET_INPUTS: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0)); // R1
endmodule

// File: tb/masked_gpio_port_bench.sv
module masked_gpio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [11:0] pad_in = '0;
  logic [11:0] pad_out, pad_oe;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] got;

  always #4 clk = ~clk;  // 125 MHz

  masked_gpio_port u_masked_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [15:0] data_addr(input logic [11:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    check("R1 pad_oe", {20'h0, pad_oe}, 32'h0);
    check("R1 pad_out", {20'h0, pad_out}, 32'h0);
    bus_read(16'h8000, got);
    check("R1 dir", got, 32'h0);
    bus_read(16'h3FFC, got);
    check("R1 R4 R7 all inputs", got, 32'h0000_0A5C);
  endtask

  task automatic t_direction;
    bus_write(16'h8000, 32'hFFFF_F0F0);
    bus_read(16'h8000, got);
    check("R5 dir readback", got, 32'h0000_00F0);
    check("R6 pad_oe", {20'h0, pad_oe}, 32'h0000_00F0);
  endtask

  task automatic t_masked_write;
    bus_write(16'h3FFC, 32'h0);
    check("R4 full clear", {20'h0, pad_out}, 32'h0);
    bus_write(data_addr(12'h0A0), 32'hFFFF_FFFF);
    check("R2 R6 set bits 5,7", {20'h0, pad_out}, 32'h0000_00A0);
    bus_write(data_addr(12'h030), 32'h0);
    check("R2 clear bits 4,5", {20'h0, pad_out}, 32'h0000_0080);
  endtask

  task automatic t_masked_read;
    pad_in = 12'hFFF;
    repeat (3) @(negedge clk);
    bus_read(16'h3FFC, got);
    check("R7 R4 mixed read", got, 32'h0000_0F8F);
    bus_read(data_addr(12'h010), got);
    check("R3 single output low", got, 32'h0);
    bus_read(data_addr(12'h080), got);
    check("R3 single output high", got, 32'h0000_0080);
    bus_read(data_addr(12'h001), got);
    check("R3 single input high", got, 32'h0000_0001);
    bus_read(data_addr(12'h801), got);
    check("R3 two inputs", got, 32'h0000_0801);
  endtask

  task automatic t_unmapped;
    bus_write(16'h4000, 32'hFFFF_FFFF);
    check("R9 unmapped write latch", {20'h0, pad_out}, 32'h0000_0080);
    bus_write(16'h8004, 32'hFFFF_FFFF);
    check("R9 unmapped write dir", {20'h0, pad_oe}, 32'h0000_00F0);
    bus_read(16'h8004, got);
    check("R9 unmapped read", got, 32'h0);
  endtask

  task automatic t_sync;
    @(negedge clk);
    pad_in = 12'h000;
    bus_addr = 16'h3FFC; bus_re = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 edge k old", bus_rdata, 32'h0000_0F8F);
    @(posedge clk); @(negedge clk);
    check("R8 edge k+1 old", bus_rdata, 32'h0000_0F8F);
    @(posedge clk); @(negedge clk);
    check("R8 edge k+2 new", bus_rdata, 32'h0000_0080);
    bus_re = 1'b0;
  endtask

  task automatic t_hold;
    pad_in = 12'hFFF;
    bus_addr = 16'h3FFC;
    repeat (4) @(negedge clk);
    check("R9 hold without re", bus_rdata, 32'h0000_0080);
  endtask

  task automatic t_out_gate;
    bus_write(data_addr(12'h001), 32'h1);
    check("R6 latch on input pin", {20'h0, pad_out}, 32'h0000_0080);
    bus_write(16'h8000, 32'h0000_00F1);
    check("R6 enable pin 0", {20'h0, pad_out}, 32'h0000_0081);
    pad_in = 12'h000;
    repeat (3) @(negedge clk);
    bus_read(data_addr(12'h001), got);
    check("R7 output pin ignores pad", got, 32'h0000_0001);
  endtask

  initial begin
    fork
      begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin : main
        pad_in = 12'hA5C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_direction();
        t_masked_write();
        t_masked_read();
        t_unmapped();
        t_sync();
        t_hold();
        t_out_gate();
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule